// File: doc/BRIEF.md
# Receive Descriptor Fill and Status Write-Back Engine

This block takes one receive descriptor at a time from memory and fills its buffers with the bytes of an incoming frame. When the frame or the buffer space runs out, it writes the descriptor's status word back. A descriptor is four consecutive 32-bit words. Word 0 carries ownership and status. Word 1 carries the two buffer sizes. Word 2 holds the first buffer's address. Word 3 holds the second buffer's address.

The host hands a descriptor over by setting its ownership bit and pulsing a poll input. The engine then reads the four words over a request/acknowledge memory port. It accepts bytes from the receive MAC one at a time and stores each byte with a single write to memory.

If the frame ends, the engine records the final length and the frame's flags. If both buffers fill first, it records the running byte count of the frame, and the next descriptor continues the count. In both cases the same status write clears ownership. Choosing the next descriptor is the surrounding logic's job.

Top module: `rxDescEngine`

## Requirements
- R1: A poll pulse while idle (or while waiting after a host-owned descriptor) latches the descriptor address. The engine then reads the words at offsets 0, 4, 8 and 12 in that order. Each request holds its address and controls until it is acknowledged.
- R2: If word 0 bit 31 is clear, the engine makes no further reads and no writes. It raises the buffer-unavailable flag and holds it until the next poll pulse, which clears the flag and refetches.
- R3: Word 1 bits 12:0 give the size of buffer one, and bits 28:16 give the size of buffer two. Byte i of the descriptor goes to word2 + i while i is below size one. After that it goes to word3 + (i − size one). A buffer of size zero is skipped.
- R4: Each byte is stored with one write. The only byte enable set is the lane given by address bits 1:0, and the byte is repeated on all four data lanes.
- R5: Ready toward the MAC is high only while the engine waits for a byte with no memory request pending. Each ready-and-valid cycle takes exactly one byte.
- R6: The status word goes to offset 0 with all four byte enables set. It is written only after the descriptor's last data write is acknowledged, and its bit 31 is 0.
- R7: When the byte flagged last has been stored, the status has bit 8 set. Bits 29:16 hold the frame's total byte count across all of its descriptors. Bit 14 is the error input and bit 30 is the address-filter-fail input, both as sampled with the last byte; their values on other bytes are ignored.
- R8: When both buffers fill before the last byte, the status has bits 8, 14 and 30 clear and bits 29:16 equal to the frame's bytes so far. The next descriptor keeps counting from that total.
- R9: A descriptor whose two sizes are both zero has its status written right after the fetch, with no data writes.
- R10: The done output is high for exactly one cycle per descriptor, in the cycle the status write is acknowledged.
- R11: After reset, the memory request, ready, buffer-unavailable and done outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pollDemand | input | 1 | Pulse: fetch the descriptor at descAddr |
| descAddr | input | 32 | Byte address of descriptor word 0 |
| bufUnavail | output | 1 | Fetched descriptor was host-owned |
| descDone | output | 1 | Status write-back acknowledged |
| rxValid | input | 1 | Receive byte valid |
| rxData | input | 8 | Receive byte |
| rxLast | input | 1 | Byte is the frame's last |
| rxErr | input | 1 | Frame error, meaningful with rxLast |
| rxAfFail | input | 1 | Address filter failed, meaningful with rxLast |
| rxReady | output | 1 | Engine accepts a byte this cycle |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Byte address of the access |
| memBe | output | 4 | Byte enables |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | One-cycle acknowledge of the current request |

## Verification
The memory model answers each request 0 to 2 cycles late. The bench therefore never assumes a fixed latency for reads or writes. It waits on the counts of acknowledged accesses, and it checks memory contents and status words two cycles after the status write has been acknowledged. Ready is one cycle behind a byte's acceptance: the byte is taken on the edge after a cycle in which ready and valid are both high. The bench offers bytes and samples ready on falling edges. Done lasts from the acknowledge to the next rising edge, so it is sampled one nanosecond before that edge.

// File: rtl/rxDescPkg.sv
package rxDescPkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int BE_W       = DATA_W / 8;
  localparam int SIZE_W     = 13;
  localparam int LEN_W      = SIZE_W + 1;
  localparam int OWN_BIT    = 31;
  localparam int AF_BIT     = 30;
  localparam int LEN_LO     = 16;
  localparam int ERR_BIT    = 14;
  localparam int LAST_BIT   = 8;
  localparam int SIZE1_LO   = 0;
  localparam int SIZE2_LO   = 16;

  typedef enum logic [1:0] {
    SEL_DESC,
    SEL_BYTE,
    SEL_STAT
  } memSelT;

  typedef struct packed {
    logic       loadBase;
    logic       clearDesc;
    logic       loadW1;
    logic       loadW2;
    logic       loadW3;
    logic       takeByte;
    logic       byteDone;
    logic       statusDone;
    memSelT     memSel;
    logic [1:0] wordIdx;
  } ctrlStrobeT;
endpackage

// File: rtl/rxDescCtrl.sv
module rxDescCtrl
  import rxDescPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pollDemand,
  input  logic       memAck,
  input  logic       ownFlag,
  input  logic       rxValid,
  input  logic       lastHeld,
  input  logic       fullNow,
  input  logic       fullAfterByte,
  output ctrlStrobeT strobe,
  output logic       memReq,
  output logic       memWe,
  output logic       rxReady,
  output logic       bufUnavail,
  output logic       descDone
);
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_NOTOWN, S_DATA, S_BYTE, S_STAT
  } stateT;

  stateT      state, stateNxt;
  logic [1:0] wordIdx, wordIdxNxt;
  logic       ownSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wordIdx <= '0;
      ownSeen <= 1'b0;
    end else begin
      state   <= stateNxt;
      wordIdx <= wordIdxNxt;
      if (strobe.clearDesc)
        ownSeen <= 1'b1;
      else if (stateNxt == S_IDLE || stateNxt == S_NOTOWN)
        ownSeen <= 1'b0;
    end
  end

  always_comb begin
    stateNxt       = state;
    wordIdxNxt     = wordIdx;
    strobe         = '0;
    strobe.memSel  = SEL_DESC;
    strobe.wordIdx = wordIdx;
    memReq         = 1'b0;
    memWe          = 1'b0;
    rxReady        = 1'b0;
    descDone       = 1'b0;
    case (state)
      S_IDLE, S_NOTOWN: begin
        if (pollDemand) begin
          strobe.loadBase = 1'b1;
          wordIdxNxt      = '0;
          stateNxt        = S_FETCH;
        end
      end
      S_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          case (wordIdx)
            2'd0: begin
              if (ownFlag) begin
                strobe.clearDesc = 1'b1;
                wordIdxNxt       = 2'd1;
              end else begin
                stateNxt = S_NOTOWN;
              end
            end
            2'd1: begin
              strobe.loadW1 = 1'b1;
              wordIdxNxt    = 2'd2;
            end
            2'd2: begin
              strobe.loadW2 = 1'b1;
              wordIdxNxt    = 2'd3;
            end
            default: begin
              strobe.loadW3 = 1'b1;
              stateNxt      = fullNow ? S_STAT : S_DATA;
            end
          endcase
        end
      end
      S_DATA: begin
        rxReady = 1'b1;
        if (rxValid) begin
          strobe.takeByte = 1'b1;
          stateNxt        = S_BYTE;
        end
      end
      S_BYTE: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        strobe.memSel = SEL_BYTE;
        if (memAck) begin
          strobe.byteDone = 1'b1;
          stateNxt        = (lastHeld || fullAfterByte) ? S_STAT : S_DATA;
        end
      end
      S_STAT: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        strobe.memSel = SEL_STAT;
        if (memAck) begin
          strobe.statusDone = 1'b1;
          descDone          = 1'b1;
          stateNxt          = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign bufUnavail = (state == S_NOTOWN);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq); // R1
  AST_WRITE_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ownSeen); // R2
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |-> !memReq); // R5
  AST_UNAVAIL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    bufUnavail |-> (!memReq && !rxReady)); // R2
endmodule

// File: rtl/rxDescPath.sv
module rxDescPath
  import rxDescPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic              memReq,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  input  logic              rxErr,
  input  logic              rxAfFail,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BE_W-1:0]   memBe,
  output logic [DATA_W-1:0] memWdata,
  output logic              lastHeld,
  output logic              fullNow,
  output logic              fullAfterByte
);
  logic [ADDR_W-1:0] descBase, buf1Addr, buf2Addr, byteAddr;
  logic [SIZE_W-1:0] buf1Size, buf2Size;
  logic [LEN_W-1:0]  descCount, frameCount, capTotal, byteOff;
  logic [7:0]        byteReg;
  logic              lastReg, errReg, afReg, inBuf2;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descBase   <= '0;
      buf1Addr   <= '0;
      buf2Addr   <= '0;
      buf1Size   <= '0;
      buf2Size   <= '0;
      descCount  <= '0;
      frameCount <= '0;
      byteReg    <= '0;
      lastReg    <= 1'b0;
      errReg     <= 1'b0;
      afReg      <= 1'b0;
    end else begin
      if (strobe.loadBase) descBase <= descAddr;
      if (strobe.clearDesc) begin
        descCount <= '0;
        lastReg   <= 1'b0;
        errReg    <= 1'b0;
        afReg     <= 1'b0;
      end
      if (strobe.loadW1) begin
        buf1Size <= memRdata[SIZE1_LO +: SIZE_W];
        buf2Size <= memRdata[SIZE2_LO +: SIZE_W];
      end
      if (strobe.loadW2) buf1Addr <= memRdata;
      if (strobe.loadW3) buf2Addr <= memRdata;
      if (strobe.takeByte) begin
        byteReg <= rxData;
        lastReg <= rxLast;
        errReg  <= rxLast & rxErr;
        afReg   <= rxLast & rxAfFail;
      end
      if (strobe.byteDone) begin
        descCount  <= descCount + LEN_W'(1);
        frameCount <= frameCount + LEN_W'(1);
      end
      if (strobe.statusDone && lastReg) frameCount <= '0;
    end
  end

  always_comb begin
    capTotal      = LEN_W'(buf1Size) + LEN_W'(buf2Size);
    fullNow       = (descCount == capTotal);
    fullAfterByte = ((descCount + LEN_W'(1)) == capTotal);
    inBuf2        = (descCount >= LEN_W'(buf1Size));
    byteOff       = inBuf2 ? (descCount - LEN_W'(buf1Size)) : descCount;
    byteAddr      = (inBuf2 ? buf2Addr : buf1Addr) + ADDR_W'(byteOff);
  end

  always_comb begin
    statusWord                    = '0;
    statusWord[LEN_LO +: LEN_W]   = frameCount;
    statusWord[LAST_BIT]          = lastReg;
    statusWord[ERR_BIT]           = errReg;
    statusWord[AF_BIT]            = afReg;
    statusWord[OWN_BIT]           = 1'b0;
  end

  always_comb begin
    memAddr  = descBase + {{(ADDR_W-4){1'b0}}, strobe.wordIdx, 2'b00};
    memBe    = '1;
    memWdata = '0;
    case (strobe.memSel)
      SEL_BYTE: begin
        memAddr  = byteAddr;
        memBe    = BE_W'(1) << byteAddr[1:0];
        memWdata = {BE_W{byteReg}};
      end
      SEL_STAT: begin
        memAddr  = descBase;
        memWdata = statusWord;
      end
      default: ;
    endcase
  end

  assign lastHeld = lastReg;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && strobe.memSel == SEL_BYTE) |-> (descCount < capTotal)); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr)); // R1
  AST_LANE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && strobe.memSel == SEL_BYTE) |-> ($countones(memBe) == 1)); // R4
endmodule

// File: rtl/rxDescEngine.sv
module rxDescEngine
  import rxDescPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pollDemand,
  input  logic [ADDR_W-1:0] descAddr,
  output logic              bufUnavail,
  output logic              descDone,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  input  logic              rxErr,
  input  logic              rxAfFail,
  output logic              rxReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BE_W-1:0]   memBe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);
  ctrlStrobeT strobe;
  logic       lastHeld, fullNow, fullAfterByte;

  rxDescCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .pollDemand(pollDemand), .memAck(memAck),
    .ownFlag(memRdata[OWN_BIT]), .rxValid(rxValid), .lastHeld(lastHeld),
    .fullNow(fullNow), .fullAfterByte(fullAfterByte), .strobe(strobe),
    .memReq(memReq), .memWe(memWe), .rxReady(rxReady),
    .bufUnavail(bufUnavail), .descDone(descDone)
  );

  rxDescPath i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memReq(memReq), .memAck(memAck),
    .memRdata(memRdata), .descAddr(descAddr), .rxData(rxData), .rxLast(rxLast),
    .rxErr(rxErr), .rxAfFail(rxAfFail), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .lastHeld(lastHeld), .fullNow(fullNow),
    .fullAfterByte(fullAfterByte)
  );
endmodule

// File: tb/test_rxDescEngine.sv
module test_rxDescEngine;
  localparam int D  = 32'h40;
  localparam int B1 = 32'h100;
  localparam int B2 = 32'h181;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pollDemand = 1'b0;
  logic [31:0] descAddr = '0;
  logic        bufUnavail, descDone, rxReady, memReq, memWe;
  logic        rxValid = 1'b0, rxLast = 1'b0, rxErr = 1'b0, rxAfFail = 1'b0;
  logic [7:0]  rxData = '0;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0]  memBe;
  logic        memAck;

  logic [7:0]  mem8 [0:1023];
  int nChecks = 0, nFails = 0;
  int nRd, nByteWr, nStatWr, laneBad, readyBad, doneCount, waitLeft, latSeq;
  logic [31:0] rdLog [0:3];

  always #5 clk = ~clk;

  rxDescEngine i_rxDescEngine (
    .clk(clk), .rstN(rstN), .pollDemand(pollDemand), .descAddr(descAddr),
    .bufUnavail(bufUnavail), .descDone(descDone), .rxValid(rxValid),
    .rxData(rxData), .rxLast(rxLast), .rxErr(rxErr), .rxAfFail(rxAfFail),
    .rxReady(rxReady), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] getWord(int a);
    return {mem8[a+3], mem8[a+2], mem8[a+1], mem8[a]};
  endfunction

  task automatic putWord(int a, logic [31:0] w);
    for (int b = 0; b < 4; b++) mem8[a+b] = w[8*b +: 8];
  endtask

  function automatic logic [7:0] pat(int f, int k);
    return 8'((f * 37 + k * 11) | 1);
  endfunction

  // memory model: acknowledges after 0..2 idle cycles, updated on falling edges
  initial begin
    memAck = 1'b0; memRdata = '0; waitLeft = 0; latSeq = 0;
    forever begin
      @(negedge clk);
      if (memReq && rxReady) readyBad++;
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (waitLeft > 0) waitLeft--;
        else begin
          int wa;
          wa = int'(memAddr[9:2]) * 4;
          if (!memWe) begin
            memRdata = getWord(wa);
            if (nRd < 4) rdLog[nRd] = memAddr;
            nRd++;
          end else begin
            if (memBe == 4'hF) nStatWr++;
            else begin
              nByteWr++;
              if (memBe != (4'b1 << memAddr[1:0]) || memWdata != {4{memWdata[7:0]}})
                laneBad++;
            end
            for (int b = 0; b < 4; b++) if (memBe[b]) mem8[wa+b] = memWdata[8*b +: 8];
          end
          memAck = 1'b1;
          waitLeft = latSeq % 3;
          latSeq++;
        end
      end
    end
  end

  // done sampled 1 ns before the rising edge
  initial begin
    doneCount = 0;
    forever begin
      @(negedge clk);
      #4;
      if (descDone) doneCount++;
    end
  end

  task automatic sendBytes(int n, bit fin, bit err, bit af, int f, int k0);
    for (int i = 0; i < n; i++) begin
      rxValid = 1'b1;
      rxData = pat(f, k0 + i);
      rxLast = fin && (i == n - 1);
      rxErr = err;
      rxAfFail = af;
      while (!rxReady) @(negedge clk);
      @(negedge clk);
    end
    rxValid = 1'b0; rxLast = 1'b0; rxErr = 1'b0; rxAfFail = 1'b0;
  endtask

  task automatic runDesc(int s1, int s2, int n, bit fin, bit err, bit af,
                         int f, int k0, int total);
    logic [31:0] expStat;
    for (int a = B1; a < B1 + 256; a++) mem8[a] = 8'h00;
    putWord(D, 32'h8000_0000);
    putWord(D + 4, {3'b0, 13'(s2), 3'b0, 13'(s1)});
    putWord(D + 8, B1);
    putWord(D + 12, B2);
    nRd = 0; nByteWr = 0; nStatWr = 0; laneBad = 0; readyBad = 0; doneCount = 0;
    descAddr = D;
    pollDemand = 1'b1;
    @(negedge clk);
    pollDemand = 1'b0;
    fork
      sendBytes(n, fin, err, af, f, k0);
      begin
        while (nStatWr == 0) @(negedge clk);
        repeat (2) @(negedge clk);
      end
    join
    expStat = {1'b0, fin & af, 14'(total), 1'b0, fin & err, 5'b0, fin, 8'b0};
    chk("R7/R8 status word", getWord(D), expStat);
    chk("R6 single status write", 32'(nStatWr), 32'd1);
    chk("R1 read count", 32'(nRd), 32'd4);
    for (int w = 0; w < 4; w++) chk("R1 read order", rdLog[w], 32'(D + 4 * w));
    chk("R3/R9 data write count", 32'(nByteWr), 32'(n));
    chk("R4 lanes", 32'(laneBad), 32'd0);
    chk("R5 ready vs request", 32'(readyBad), 32'd0);
    chk("R10 done pulse count", 32'(doneCount), 32'd1);
    for (int j = 0; j < n; j++) begin
      int a;
      a = (j < s1) ? (B1 + j) : (B2 + j - s1);
      chk("R3 buffer byte", 32'(mem8[a]), 32'(pat(f, k0 + j)));
    end
    chk("R3 buffer one bound", 32'(mem8[B1 + s1]), 32'd0);
    chk("R3 buffer two bound", 32'(mem8[B2 + s2]), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int frameIdx;
    for (int a = 0; a < 1024; a++) mem8[a] = 8'h00;
    nRd = 0; nByteWr = 0; nStatWr = 0; laneBad = 0; readyBad = 0;
    repeat (3) @(negedge clk);
    chk("R11 memReq", 32'(memReq), 32'd0);
    chk("R11 rxReady", 32'(rxReady), 32'd0);
    chk("R11 bufUnavail", 32'(bufUnavail), 32'd0);
    chk("R11 descDone", 32'(descDone), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: host-owned descriptor
    putWord(D, 32'h0000_1234);
    nRd = 0; nByteWr = 0; nStatWr = 0;
    descAddr = D;
    pollDemand = 1'b1;
    @(negedge clk);
    pollDemand = 1'b0;
    repeat (10) @(negedge clk);
    chk("R2 unavailable flag", 32'(bufUnavail), 32'd1);
    chk("R2 single read", 32'(nRd), 32'd1);
    chk("R2 no writes", 32'(nByteWr + nStatWr), 32'd0);
    chk("R2 no request", 32'(memReq), 32'd0);
    chk("R2 word unchanged", getWord(D), 32'h0000_1234);

    // R9: both sizes zero, then R2 flag cleared by the poll
    runDesc(0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0, 0);
    chk("R2 flag cleared", 32'(bufUnavail), 32'd0);

    // R3 R7 R8: sweep of buffer sizes and frame lengths
    frameIdx = 1;
    for (int s1 = 0; s1 < 4; s1++) begin
      for (int s2 = 0; s2 < 4; s2++) begin
        if (s1 + s2 == 0) continue;
        for (int len = 1; len < 8; len++) begin
          int left, sent;
          bit err, af;
          left = len; sent = 0;
          err = (frameIdx % 3 == 1);
          af = (frameIdx % 4 >= 2);
          while (left > 0) begin
            int n;
            n = (left < s1 + s2) ? left : (s1 + s2);
            runDesc(s1, s2, n, n == left, err, af, frameIdx, sent, sent + n);
            sent += n;
            left -= n;
          end
          frameIdx++;
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule